// File: doc/BRIEF.md
# UART Receive Ring Writer

This block sits behind an asynchronous serial receiver. It takes each byte the receiver marks valid and stores it in a circular buffer through a single synchronous memory write port. The block works like a DMA channel dedicated to one receive stream. A consumer, usually firmware servicing interrupts, learns about stored data through completion events. Each event carries the start index and the byte count of a contiguous span that nobody has reported yet.

There are three kinds of event:
- a half event, when the write position crosses the midpoint of the programmed length;
- a full event, when the write position reaches the end of the buffer and wraps to the start;
- a timeout event, when the stream goes quiet with a partial span still waiting.

The timeout length is a cycle count that software derives from the baud rate and the buffer length. Every event moves the report pointer to the write position in the same cycle. Because of this, a byte caught in the expiry cycle is folded into the timeout span, and no later event reports it again.

The consumer hands space back by releasing byte counts. A byte that finds every slot still held is dropped, and an overrun is recorded. Per-kind flags stay set until cleared by a write-one-to-clear strobe.

Top module: `uart_rx_ring_writer`

## Requirements
- R1: Each accepted byte is written at the next buffer index, starting at 0 after reset and wrapping to 0 after index `cfg_len_i-1`. The write appears on the memory port after the clock edge that sampled `rx_valid_i`.
- R2: A half event (`evt_kind_o` = 1) is issued when a byte brings the write position to `cfg_len_i/2`.
- R3: A full event (`evt_kind_o` = 2) is issued when a byte brings the write position to `cfg_len_i`, and the next byte goes to index 0.
- R4: Each event reports `evt_start_o` equal to the report pointer and `evt_cnt_o` equal to all bytes accepted since the previous event. After the event, the report pointer equals the write position, so no byte is skipped or reported twice.
- R5: If unreported bytes exist and `cfg_tmo_i` clock edges pass after the edge that accepted the last byte, with no half or full event, a timeout event (`evt_kind_o` = 3) reports them. It is issued on that `cfg_tmo_i`-th edge.
- R6: A byte accepted on the same edge as a timeout expiry is included in that timeout span.
- R7: Every accepted byte restarts the idle timer. With no unreported bytes the timer is held, and no timeout event occurs however long the line stays idle.
- R8: Occupancy is the number of accepted bytes minus the released bytes (`rel_cnt_i` when `rel_valid_i` is high, effective from the next cycle). A byte arriving while occupancy equals `cfg_len_i` is dropped with no memory write, and overrun flag bit 3 is set.
- R9: `flags_o` bits are sticky: bit 0 half, bit 1 full, bit 2 timeout, bit 3 overrun. A one in `clr_i` clears the matching bit, and a set in the same cycle wins over the clear.
- R10: While reset is asserted and right after it, `mem_we_o`, `evt_valid_o`, `evt_cnt_o` and `flags_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rx_valid_i | input | 1 | Receiver presents a byte this cycle |
| rx_data_i | input | DATA_W | Received byte |
| cfg_len_i | input | ADDR_W+1 | Buffer length in bytes, even, 2 to 2^ADDR_W |
| cfg_tmo_i | input | TMO_W | Idle timeout in clock cycles, at least 1 |
| rel_valid_i | input | 1 | Consumer returns space this cycle |
| rel_cnt_i | input | ADDR_W+1 | Number of bytes returned |
| clr_i | input | 4 | Write-one-to-clear strobes for the flags |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | ADDR_W | Memory write index |
| mem_wdata_o | output | DATA_W | Memory write data |
| evt_valid_o | output | 1 | One-cycle event pulse |
| evt_kind_o | output | 2 | 1 half, 2 full, 3 timeout |
| evt_start_o | output | ADDR_W | First index of the reported span |
| evt_cnt_o | output | ADDR_W+1 | Byte count of the reported span |
| flags_o | output | 4 | Sticky half, full, timeout and overrun flags |

## Verification
Memory writes, event pulses and flag updates are all registered on the same edge that samples the byte, so each is due one edge after its stimulus. The bench drives inputs on the falling edge and reads results a moment after the next falling edge. A timeout is due exactly `cfg_tmo_i` edges after the last accepted byte. The bench checks that no event exists one edge before that point and that one exists at it. For the expiry race, the second byte is placed on exactly the expiry edge, and the bench checks that it joins the timeout span.

// File: rtl/urw_pkg.sv
package urw_pkg;
  typedef enum logic [1:0] {
    EVT_NONE = 2'd0,
    EVT_HALF = 2'd1,
    EVT_FULL = 2'd2,
    EVT_TMO  = 2'd3
  } evt_kind_e;

  localparam int FLG_HALF = 0;
  localparam int FLG_FULL = 1;
  localparam int FLG_TMO  = 2;
  localparam int FLG_OVR  = 3;
  localparam int FLG_W    = 4;
endpackage

// File: rtl/urw_ptr_ctrl.sv
module urw_ptr_ctrl #(
  parameter int ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_i,
  input  logic [ADDR_W:0]   cfg_len_i,
  output logic [ADDR_W-1:0] wr_idx_o,
  output logic [ADDR_W-1:0] wr_after_o,
  output logic              half_o,
  output logic              full_o
);
  logic [ADDR_W-1:0] wr_q;
  logic [ADDR_W:0]   inc;
  logic [ADDR_W-1:0] wr_nxt;

  always_comb begin
    inc        = {1'b0, wr_q} + 1'b1;
    half_o     = acc_i && (inc == (cfg_len_i >> 1));
    full_o     = acc_i && (inc == cfg_len_i);
    wr_nxt     = full_o ? '0 : inc[ADDR_W-1:0];
    wr_after_o = acc_i ? wr_nxt : wr_q;
    wr_idx_o   = wr_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wr_q <= '0;
    else         wr_q <= wr_after_o;
  end

  // R1
  wr_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {1'b0, wr_q} < cfg_len_i);
endmodule

// File: rtl/urw_idle_timer.sv
module urw_idle_timer #(
  parameter int TMO_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_i,
  input  logic             pend_nz_i,
  input  logic [TMO_W-1:0] cfg_tmo_i,
  output logic             hit_o
);
  logic [TMO_W-1:0] tmr_q;
  logic [TMO_W:0]   elapsed;

  always_comb begin
    elapsed = {1'b0, tmr_q} + 1'b1;
    hit_o   = pend_nz_i && (elapsed >= {1'b0, cfg_tmo_i});
  end

  // restart on byte or flush, hold while nothing is pending
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           tmr_q <= '0;
    else if (acc_i || hit_o || !pend_nz_i) tmr_q <= '0;
    else                                   tmr_q <= elapsed[TMO_W-1:0];
  end
endmodule

// File: rtl/urw_report.sv
module urw_report
  import urw_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_i,
  input  logic              half_i,
  input  logic              full_i,
  input  logic              tmo_i,
  input  logic [ADDR_W-1:0] wr_after_i,
  input  logic [ADDR_W:0]   cfg_len_i,
  output logic              pend_nz_o,
  output logic              fire_tmo_o,
  output logic              evt_valid_o,
  output logic [1:0]        evt_kind_o,
  output logic [ADDR_W-1:0] evt_start_o,
  output logic [ADDR_W:0]   evt_cnt_o
);
  logic [ADDR_W-1:0] rd_q;
  logic [ADDR_W:0]   pend_q;
  logic [ADDR_W:0]   cnt_d;
  logic              fire;
  evt_kind_e         kind_d;

  always_comb begin
    cnt_d      = pend_q + {{ADDR_W{1'b0}}, acc_i};
    fire       = half_i || full_i || tmo_i;
    fire_tmo_o = tmo_i && !half_i && !full_i;
    if (half_i)      kind_d = EVT_HALF;
    else if (full_i) kind_d = EVT_FULL;
    else             kind_d = EVT_TMO;
    pend_nz_o  = (pend_q != '0);
  end

  // span handoff: report and pointer move in one cycle, the current byte included
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q        <= '0;
      pend_q      <= '0;
      evt_valid_o <= 1'b0;
      evt_kind_o  <= EVT_NONE;
      evt_start_o <= '0;
      evt_cnt_o   <= '0;
    end else if (fire) begin
      rd_q        <= wr_after_i;
      pend_q      <= '0;
      evt_valid_o <= 1'b1;
      evt_kind_o  <= kind_d;
      evt_start_o <= rd_q;
      evt_cnt_o   <= cnt_d;
    end else begin
      pend_q      <= cnt_d;
      evt_valid_o <= 1'b0;
    end
  end

  // R2
  half_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_valid_o && evt_kind_o == EVT_HALF |->
      ({2'b0, evt_start_o} + {1'b0, evt_cnt_o}) == {1'b0, cfg_len_i >> 1});
  // R3
  full_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_valid_o && evt_kind_o == EVT_FULL |->
      ({2'b0, evt_start_o} + {1'b0, evt_cnt_o}) == {1'b0, cfg_len_i});
  // R4
  evt_cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_valid_o |-> evt_cnt_o != '0 && evt_cnt_o <= cfg_len_i);
  // R4
  pend_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q < cfg_len_i);
endmodule

// File: rtl/urw_space.sv
module urw_space #(
  parameter int ADDR_W = 10
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            acc_i,
  input  logic            rel_valid_i,
  input  logic [ADDR_W:0] rel_cnt_i,
  input  logic [ADDR_W:0] cfg_len_i,
  output logic            room_o
);
  logic [ADDR_W:0] occ_q;
  logic [ADDR_W:0] rel_amt;

  always_comb begin
    rel_amt = rel_valid_i ? rel_cnt_i : '0;
    room_o  = occ_q < cfg_len_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) occ_q <= '0;
    else         occ_q <= occ_q + {{ADDR_W{1'b0}}, acc_i} - rel_amt;
  end

  // R8
  occ_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ_q <= cfg_len_i);
  // R8
  rel_le_occ_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rel_valid_i |-> rel_cnt_i <= occ_q);
endmodule

// File: rtl/urw_flags.sv
module urw_flags
  import urw_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [FLG_W-1:0] set_i,
  input  logic [FLG_W-1:0] clr_i,
  output logic [FLG_W-1:0] flags_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_o <= '0;
    else         flags_o <= (flags_o & ~clr_i) | set_i;
  end

  for (genvar g = 0; g < FLG_W; g++) begin : g_chk
    // R9
    flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flags_o[g] && !clr_i[g] |=> flags_o[g]);
  end
endmodule

// File: rtl/uart_rx_ring_writer.sv
module uart_rx_ring_writer
  import urw_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8,
  parameter int TMO_W  = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic [ADDR_W:0]   cfg_len_i,
  input  logic [TMO_W-1:0]  cfg_tmo_i,
  input  logic              rel_valid_i,
  input  logic [ADDR_W:0]   rel_cnt_i,
  input  logic [3:0]        clr_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              evt_valid_o,
  output logic [1:0]        evt_kind_o,
  output logic [ADDR_W-1:0] evt_start_o,
  output logic [ADDR_W:0]   evt_cnt_o,
  output logic [3:0]        flags_o
);
  logic              room, acc, drop;
  logic [ADDR_W-1:0] wr_idx, wr_after;
  logic              half, full, tmo_hit, pend_nz, fire_tmo;
  logic [FLG_W-1:0]  flag_set;

  always_comb begin
    acc  = rx_valid_i && room;
    drop = rx_valid_i && !room;
  end

  urw_space #(.ADDR_W(ADDR_W)) u_space (
    .clk_i, .rst_ni,
    .acc_i       (acc),
    .rel_valid_i,
    .rel_cnt_i,
    .cfg_len_i,
    .room_o      (room)
  );

  urw_ptr_ctrl #(.ADDR_W(ADDR_W)) u_ptr (
    .clk_i, .rst_ni,
    .acc_i      (acc),
    .cfg_len_i,
    .wr_idx_o   (wr_idx),
    .wr_after_o (wr_after),
    .half_o     (half),
    .full_o     (full)
  );

  urw_idle_timer #(.TMO_W(TMO_W)) u_tmr (
    .clk_i, .rst_ni,
    .acc_i     (acc),
    .pend_nz_i (pend_nz),
    .cfg_tmo_i,
    .hit_o     (tmo_hit)
  );

  urw_report #(.ADDR_W(ADDR_W)) u_rep (
    .clk_i, .rst_ni,
    .acc_i       (acc),
    .half_i      (half),
    .full_i      (full),
    .tmo_i       (tmo_hit),
    .wr_after_i  (wr_after),
    .cfg_len_i,
    .pend_nz_o   (pend_nz),
    .fire_tmo_o  (fire_tmo),
    .evt_valid_o,
    .evt_kind_o,
    .evt_start_o,
    .evt_cnt_o
  );

  always_comb begin
    flag_set           = '0;
    flag_set[FLG_HALF] = half;
    flag_set[FLG_FULL] = full;
    flag_set[FLG_TMO]  = fire_tmo;
    flag_set[FLG_OVR]  = drop;
  end

  urw_flags u_flags (
    .clk_i, .rst_ni,
    .set_i   (flag_set),
    .clr_i,
    .flags_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_we_o    <= 1'b0;
      mem_addr_o  <= '0;
      mem_wdata_o <= '0;
    end else begin
      mem_we_o <= acc;
      if (acc) begin
        mem_addr_o  <= wr_idx;
        mem_wdata_o <= rx_data_i;
      end
    end
  end

  // R8
  drop_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i && !room |=> !mem_we_o);
  // R5
  tmo_evt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_tmo |=> evt_valid_o && evt_kind_o == EVT_TMO);
  // R1
  write_follows_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> mem_we_o && mem_wdata_o == $past(rx_data_i));
endmodule

// File: tb/uart_rx_ring_writer_bench.sv
module uart_rx_ring_writer_bench;
  localparam int CLK_P  = 10;
  localparam int AW     = 4;
  localparam int TW     = 8;
  localparam int LEN    = 8;
  localparam int TMO    = 5;

  typedef struct packed {
    int nb;
    int nev;
    int kind;
    int st;
    int cnt;
  } vec_t;

  // bytes sent, events expected, last event kind/start/count
  localparam vec_t VEC [7] = '{
    '{2, 1, 3, 0, 2},
    '{2, 1, 1, 2, 2},
    '{4, 1, 2, 4, 4},
    '{5, 2, 3, 4, 1},
    '{3, 1, 2, 5, 3},
    '{6, 2, 3, 4, 2},
    '{8, 3, 3, 4, 2}
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          rx_valid_i = 1'b0;
  logic [7:0]    rx_data_i = '0;
  logic [AW:0]   cfg_len_i = LEN[AW:0];
  logic [TW-1:0] cfg_tmo_i = TMO[TW-1:0];
  logic          rel_valid_i = 1'b0;
  logic [AW:0]   rel_cnt_i = '0;
  logic [3:0]    clr_i = '0;
  logic          mem_we_o;
  logic [AW-1:0] mem_addr_o;
  logic [7:0]    mem_wdata_o;
  logic          evt_valid_o;
  logic [1:0]    evt_kind_o;
  logic [AW-1:0] evt_start_o;
  logic [AW:0]   evt_cnt_o;
  logic [3:0]    flags_o;

  uart_rx_ring_writer #(.ADDR_W(AW), .DATA_W(8), .TMO_W(TW)) u_uart_rx_ring_writer (
    .clk_i, .rst_ni, .rx_valid_i, .rx_data_i, .cfg_len_i, .cfg_tmo_i,
    .rel_valid_i, .rel_cnt_i, .clr_i, .mem_we_o, .mem_addr_o, .mem_wdata_o,
    .evt_valid_o, .evt_kind_o, .evt_start_o, .evt_cnt_o, .flags_o
  );

  always #(CLK_P/2) clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0;
  int ev_n = 0, ev_kind = 0, ev_st = 0, ev_cnt = 0;
  int wr_n = 0, wr_addr = 0, wr_data = 0;
  int tx_n = 0, exp_n = 0;
  bit stream_en = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic eq(input string req, input int act, input int exp);
    check(act == exp, req, act, exp);
  endtask

  // monitor, half a period after the active edge
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (evt_valid_o) begin
        ev_n++;
        ev_kind = int'(evt_kind_o);
        ev_st   = int'(evt_start_o);
        ev_cnt  = int'(evt_cnt_o);
      end
      if (mem_we_o) begin
        wr_n++;
        wr_addr = int'(mem_addr_o);
        wr_data = int'(mem_wdata_o);
        if (stream_en) begin
          eq("R1 addr", wr_addr, exp_n % LEN);
          eq("R1 data", wr_data, exp_n % 256);
          exp_n++;
        end
      end
    end
  end

  task automatic settle();
    #1;
  endtask

  task automatic send(input logic [7:0] d);
    rx_valid_i = 1'b1;
    rx_data_i  = d;
    @(negedge clk_i);
  endtask

  task automatic idle(input int n);
    rx_valid_i = 1'b0;
    repeat (n) @(negedge clk_i);
  endtask

  task automatic release_bytes(input int n);
    rx_valid_i  = 1'b0;
    rel_valid_i = 1'b1;
    rel_cnt_i   = n[AW:0];
    @(negedge clk_i);
    rel_valid_i = 1'b0;
  endtask

  task automatic do_reset();
    rx_valid_i = 1'b0; rel_valid_i = 1'b0; clr_i = '0;
    @(negedge clk_i);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    ev_n = 0; wr_n = 0;
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_up();
  end

  initial begin
    // R10 reset state
    repeat (2) @(negedge clk_i);
    settle();
    eq("R10 we", int'(mem_we_o), 0);
    eq("R10 evt", int'(evt_valid_o), 0);
    eq("R10 flags", int'(flags_o), 0);
    do_reset();
    settle();
    eq("R10 cnt", int'(evt_cnt_o), 0);
    eq("R10 flags after", int'(flags_o), 0);

    // table walk: R2 R3 R4 R5 with wrap
    stream_en = 1'b1;
    foreach (VEC[i]) begin
      ev_n = 0;
      for (int b = 0; b < VEC[i].nb; b++) begin
        send(tx_n[7:0]);
        tx_n++;
      end
      idle(3 * TMO);
      settle();
      eq("R4 event count", ev_n, VEC[i].nev);
      eq("R2 R3 R5 kind", ev_kind, VEC[i].kind);
      eq("R4 start", ev_st, VEC[i].st);
      eq("R4 count", ev_cnt, VEC[i].cnt);
      release_bytes(VEC[i].nb);
    end
    eq("R1 writes", exp_n, tx_n);
    stream_en = 1'b0;

    // R6 byte on the expiry edge joins the timeout span
    do_reset();
    send(8'h10);
    idle(TMO - 1);
    send(8'h11);
    idle(4 * TMO);
    settle();
    eq("R6 events", ev_n, 1);
    eq("R6 kind", ev_kind, 3);
    eq("R6 count", ev_cnt, 2);
    eq("R6 start", ev_st, 0);

    // R7 restart on each byte, R5 exact latency
    do_reset();
    send(8'h20); idle(TMO - 2);
    send(8'h21); idle(TMO - 2);
    send(8'h22);
    idle(TMO - 1);
    settle();
    eq("R7 no early timeout", ev_n, 0);
    idle(1);
    settle();
    eq("R5 timeout due", ev_n, 1);
    eq("R7 count", ev_cnt, 3);
    eq("R5 flag", int'(flags_o), 4'b0100);

    // R7 held with nothing pending
    do_reset();
    for (int b = 0; b < 4; b++) send(8'h30 + 8'(b));
    idle(6 * TMO);
    settle();
    eq("R7 held", ev_n, 1);
    eq("R2 kind", ev_kind, 1);
    eq("R9 half flag", int'(flags_o), 4'b0001);

    // R8 overrun
    do_reset();
    for (int b = 0; b < LEN; b++) send(8'h40 + 8'(b));
    send(8'hEE);
    settle();
    eq("R8 flags", int'(flags_o), 4'b1011);
    eq("R8 no write", wr_n, LEN);
    eq("R3 wrap events", ev_n, 2);
    release_bytes(LEN);
    send(8'h5A);
    settle();
    eq("R8 write after release", wr_n, LEN + 1);
    eq("R3 wrap addr", wr_addr, 0);
    eq("R8 data", wr_data, 8'h5A);
    idle(4 * TMO);
    settle();
    eq("R9 all set", int'(flags_o), 4'b1111);

    // R9 write-one-to-clear and stickiness
    clr_i = 4'b0001;
    @(negedge clk_i);
    clr_i = 4'b0000;
    settle();
    eq("R9 clear one", int'(flags_o), 4'b1110);
    idle(3);
    settle();
    eq("R9 sticky", int'(flags_o), 4'b1110);
    clr_i = 4'b1111;
    @(negedge clk_i);
    clr_i = 4'b0000;
    settle();
    eq("R9 clear all", int'(flags_o), 0);

    finish_up();
  end
endmodule